// File: doc/BRIEF.md
# Completion-Pointer Interrupt Acknowledge Controller

This block keeps the per-channel packet-completion interrupts of an eight-channel DMA engine. Each channel has one completion-pointer register. When the DMA side finishes a packet, it writes the address of that packet's last buffer descriptor into the channel's pointer. That write stores the address and marks the channel pending, whatever value is written.

The host acknowledges through a small word-addressed register bus. It writes the address of the last descriptor it has processed to the same pointer address. The block compares that value with the stored pointer and never writes it into the register. The pending state clears only on a match. A mismatch means the DMA has completed packets the host has not yet seen, so the interrupt stays up.

A per-channel enable vector is changed through separate set and clear registers. Raw and masked status registers report the pending state. Each channel drives its own level interrupt output, and a combined output is the OR of all masked channels.

Register map (word addresses): 0 enable-set, 1 enable-clear, 2 raw status, 3 masked status, 8 to 15 completion pointer of channels 0 to 7.

Top module: `cp_irq_ctrl`

## Requirements
- R1: After reset, every completion pointer reads 0, the enable vector reads 0, raw and masked status read 0, and irq_o and irq_any_o are low.
- R2: A DMA write (dma_we_i with channel dma_ch_i) stores dma_ptr_i in that channel's pointer and sets its pending bit from the next cycle. This holds even when the value equals the pointer already stored.
- R3: A host write to address 8+c whose data equals channel c's stored pointer clears channel c's pending bit from the next cycle.
- R4: A host write to address 8+c whose data differs from the stored pointer leaves the pending bit set. No host write ever changes a stored pointer.
- R5: A read of address 8+c returns the value channel c's pointer last received from the DMA side.
- R6: A write to address 0 sets every enable bit whose data bit is 1, and leaves bits written with 0 unchanged. Reads of address 0 or 1 return the enable vector in bits [7:0].
- R7: A write to address 1 clears every enable bit whose data bit is 1, and leaves bits written with 0 unchanged.
- R8: Raw status (address 2) bit c is channel c's pending bit, independent of its enable. Masked status (address 3) and irq_o[c] are pending AND enabled.
- R9: irq_any_o is high exactly when some bit of irq_o is high.
- R10: When a DMA write and a host acknowledge reach the same channel in one cycle, the DMA write takes effect: the pointer takes the DMA value and the channel stays pending. When they reach different channels, both take effect.
- R11: Writes to addresses 2 and 3 have no effect. Reads of any address with no register behind it return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_we_i | input | 1 | DMA-side completion-pointer write strobe |
| dma_ch_i | input | 3 | Channel of the DMA write |
| dma_ptr_i | input | 32 | Last finished descriptor address |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 5 | Host register word address |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 8 | Per-channel masked level interrupts |
| irq_any_o | output | 1 | OR of all masked interrupts |

## Verification
Properties run on every cycle and check the following:
- A DMA write sets pending and loads the pointer.
- A pending bit falls only after a host write whose data matches that channel's pointer.
- A mismatched acknowledge leaves the channel pending.
- A pointer changes only on a DMA write.
- An enable bit rises only through the set register and falls only through the clear register.
- The combined interrupt follows the per-channel outputs.

Only the bench's scenarios can show the following:
- Exact readback values through the register bus.
- That writes of zero bits and writes to status addresses change nothing.
- That unmapped reads return 0.
- The ordering outcome when a DMA write and an acknowledge meet on one channel.
- The state after a mid-run reset.

// File: rtl/cp_irq_pkg.sv
package cp_irq_pkg;
  localparam int unsigned ADR_MSET = 0;
  localparam int unsigned ADR_MCLR = 1;
  localparam int unsigned ADR_RAW  = 2;
  localparam int unsigned ADR_MSK  = 3;
  localparam int unsigned ADR_CP   = 8;  // first completion pointer
endpackage

// File: rtl/cp_irq_chan.sv
module cp_irq_chan #(
  parameter int unsigned PTR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dma_we_i,
  input  logic [PTR_W-1:0] dma_ptr_i,
  input  logic             ack_we_i,
  input  logic [PTR_W-1:0] ack_ptr_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             pend_o
);
  logic [PTR_W-1:0] ptr_q;
  logic             pend_q;
  logic             ack_hit;

  assign ack_hit = ack_we_i && (ack_ptr_i == ptr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      pend_q <= 1'b0;
    end else if (dma_we_i) begin
      // DMA write wins over a same-cycle acknowledge
      ptr_q  <= dma_ptr_i;
      pend_q <= 1'b1;
    end else if (ack_hit) begin
      pend_q <= 1'b0;
    end
  end

  assign ptr_o  = ptr_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/cp_irq_mask.sv
module cp_irq_mask #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_we_i,
  input  logic            clr_we_i,
  input  logic [N_CH-1:0] bits_i,
  output logic [N_CH-1:0] en_o
);
  logic [N_CH-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= '0;
    else if (set_we_i) en_q <= en_q | bits_i;
    else if (clr_we_i) en_q <= en_q & ~bits_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/cp_irq_regif.sv
module cp_irq_regif
  import cp_irq_pkg::*;
#(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned PTR_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                       reg_we_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [DATA_W-1:0]          reg_wdata_i,
  input  logic [N_CH-1:0]            en_i,
  input  logic [N_CH-1:0]            raw_i,
  input  logic [N_CH-1:0][PTR_W-1:0] ptr_i,
  output logic                       mset_we_o,
  output logic                       mclr_we_o,
  output logic [N_CH-1:0]            ack_we_o,
  output logic [PTR_W-1:0]           ack_ptr_o,
  output logic [DATA_W-1:0]          reg_rdata_o
);
  logic [ADDR_W-1:0] cp_off;
  logic              cp_sel;
  logic [CH_W-1:0]   cp_idx;
  logic [N_CH-1:0]   msk;

  assign cp_off = reg_addr_i - ADDR_W'(ADR_CP);
  assign cp_sel = (reg_addr_i >= ADDR_W'(ADR_CP)) && (cp_off < ADDR_W'(N_CH));
  assign cp_idx = CH_W'(cp_off);
  assign msk    = raw_i & en_i;

  assign mset_we_o = reg_we_i && (reg_addr_i == ADDR_W'(ADR_MSET));
  assign mclr_we_o = reg_we_i && (reg_addr_i == ADDR_W'(ADR_MCLR));
  assign ack_ptr_o = PTR_W'(reg_wdata_i);

  for (genvar c = 0; c < N_CH; c++) begin : g_ack
    assign ack_we_o[c] = reg_we_i && cp_sel && (cp_idx == CH_W'(c));
  end

  always_comb begin
    reg_rdata_o = '0;
    if (cp_sel) begin
      reg_rdata_o = DATA_W'(ptr_i[cp_idx]);
    end else begin
      case (reg_addr_i)
        ADDR_W'(ADR_MSET),
        ADDR_W'(ADR_MCLR): reg_rdata_o = DATA_W'(en_i);
        ADDR_W'(ADR_RAW):  reg_rdata_o = DATA_W'(raw_i);
        ADDR_W'(ADR_MSK):  reg_rdata_o = DATA_W'(msk);
        default:           reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/cp_irq_ctrl.sv
module cp_irq_ctrl #(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned PTR_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_we_i,
  input  logic [CH_W-1:0]   dma_ch_i,
  input  logic [PTR_W-1:0]  dma_ptr_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N_CH-1:0]   irq_o,
  output logic              irq_any_o
);
  logic [N_CH-1:0]            ch_pend;
  logic [N_CH-1:0][PTR_W-1:0] ch_ptr;
  logic [N_CH-1:0]            mask_en;
  logic [N_CH-1:0]            ack_we;
  logic [PTR_W-1:0]           ack_ptr;
  logic                       mset_we;
  logic                       mclr_we;

  cp_irq_regif #(
    .N_CH(N_CH), .PTR_W(PTR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regif (
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .en_i       (mask_en),
    .raw_i      (ch_pend),
    .ptr_i      (ch_ptr),
    .mset_we_o  (mset_we),
    .mclr_we_o  (mclr_we),
    .ack_we_o   (ack_we),
    .ack_ptr_o  (ack_ptr),
    .reg_rdata_o(reg_rdata_o)
  );

  cp_irq_mask #(.N_CH(N_CH)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_we_i(mset_we),
    .clr_we_i(mclr_we),
    .bits_i  (reg_wdata_i[N_CH-1:0]),
    .en_o    (mask_en)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic dma_sel;
    assign dma_sel = dma_we_i && (dma_ch_i == CH_W'(c));
    cp_irq_chan #(.PTR_W(PTR_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .dma_we_i (dma_sel),
      .dma_ptr_i(dma_ptr_i),
      .ack_we_i (ack_we[c]),
      .ack_ptr_i(ack_ptr),
      .ptr_o    (ch_ptr[c]),
      .pend_o   (ch_pend[c])
    );
  end

  assign irq_o     = ch_pend & mask_en;
  assign irq_any_o = |irq_o;
endmodule

// File: rtl/cp_irq_ctrl_chk.sv
module cp_irq_ctrl_chk
  import cp_irq_pkg::*;
#(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned PTR_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       dma_we_i,
  input logic [CH_W-1:0]            dma_ch_i,
  input logic [PTR_W-1:0]           dma_ptr_i,
  input logic                       reg_we_i,
  input logic [ADDR_W-1:0]          reg_addr_i,
  input logic [DATA_W-1:0]          reg_wdata_i,
  input logic [N_CH-1:0]            ch_pend,
  input logic [N_CH-1:0][PTR_W-1:0] ch_ptr,
  input logic [N_CH-1:0]            mask_en,
  input logic [N_CH-1:0]            irq_o,
  input logic                       irq_any_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    // R2
    dma_sets_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dma_we_i && dma_ch_i == CH_W'(c)) |=> ch_pend[c]);
    // R10
    dma_ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dma_we_i && dma_ch_i == CH_W'(c)) |=> (ch_ptr[c] == $past(dma_ptr_i)));
    // R3
    pend_clr_by_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ch_pend[c]) |-> $past(reg_we_i && reg_addr_i == ADDR_W'(ADR_CP + c)
                                  && PTR_W'(reg_wdata_i) == ch_ptr[c]));
    // R4
    mismatch_keeps_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_pend[c] && reg_we_i && reg_addr_i == ADDR_W'(ADR_CP + c)
       && PTR_W'(reg_wdata_i) != ch_ptr[c]) |=> ch_pend[c]);
    // R4
    ptr_only_dma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(dma_we_i && dma_ch_i == CH_W'(c)) |-> $stable(ch_ptr[c]));
    // R6
    en_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(mask_en[c]) |-> $past(reg_we_i && reg_addr_i == ADDR_W'(ADR_MSET)
                                  && reg_wdata_i[c]));
    // R7
    en_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(mask_en[c]) |-> $past(reg_we_i && reg_addr_i == ADDR_W'(ADR_MCLR)
                                  && reg_wdata_i[c]));
    // R8
    irq_needs_pend_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> (ch_pend[c] && mask_en[c]));
  end

  // R9
  irq_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_any_o == (irq_o != '0));
endmodule

bind cp_irq_ctrl cp_irq_ctrl_chk #(
  .N_CH(N_CH), .PTR_W(PTR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dma_we_i   (dma_we_i),
  .dma_ch_i   (dma_ch_i),
  .dma_ptr_i  (dma_ptr_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .ch_pend    (ch_pend),
  .ch_ptr     (ch_ptr),
  .mask_en    (mask_en),
  .irq_o      (irq_o),
  .irq_any_o  (irq_any_o)
);

// File: tb/tb_cp_irq_ctrl.sv
`timescale 1ns/1ps
module tb_cp_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dma_we = 1'b0;
  logic [2:0]  dma_ch = '0;
  logic [31:0] dma_ptr = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  irq;
  logic        irq_any;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cp_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .dma_we_i(dma_we), .dma_ch_i(dma_ch), .dma_ptr_i(dma_ptr),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq), .irq_any_o(irq_any)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        dwe;
    logic [2:0]  dch;
    logic [31:0] dptr;
    logic        we;
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [4:0]  raddr;
    logic [31:0] exp_rd;
    logic [7:0]  exp_irq;
  } vec_t;

  localparam int N_VEC = 20;
  localparam vec_t VECS [N_VEC] = '{
    '{4'd1,  1'b0, 3'd0, 32'h0,   1'b0, 5'd0,  32'h0,   5'd2,  32'h0,   8'h00}, // R1
    '{4'd1,  1'b0, 3'd0, 32'h0,   1'b0, 5'd0,  32'h0,   5'd11, 32'h0,   8'h00}, // R1
    '{4'd2,  1'b1, 3'd2, 32'h100, 1'b0, 5'd0,  32'h0,   5'd2,  32'h4,   8'h00}, // R2
    '{4'd6,  1'b0, 3'd0, 32'h0,   1'b1, 5'd0,  32'h4,   5'd3,  32'h4,   8'h04}, // R6
    '{4'd4,  1'b0, 3'd0, 32'h0,   1'b1, 5'd10, 32'hFF,  5'd10, 32'h100, 8'h04}, // R4
    '{4'd5,  1'b1, 3'd2, 32'h140, 1'b0, 5'd0,  32'h0,   5'd10, 32'h140, 8'h04}, // R5
    '{4'd4,  1'b0, 3'd0, 32'h0,   1'b1, 5'd10, 32'h100, 5'd2,  32'h4,   8'h04}, // R4
    '{4'd3,  1'b0, 3'd0, 32'h0,   1'b1, 5'd10, 32'h140, 5'd2,  32'h0,   8'h00}, // R3
    '{4'd2,  1'b1, 3'd2, 32'h140, 1'b0, 5'd0,  32'h0,   5'd2,  32'h4,   8'h04}, // R2
    '{4'd6,  1'b0, 3'd0, 32'h0,   1'b1, 5'd0,  32'hF0,  5'd1,  32'hF4,  8'h04}, // R6
    '{4'd8,  1'b1, 3'd7, 32'hABC, 1'b0, 5'd0,  32'h0,   5'd3,  32'h84,  8'h84}, // R8
    '{4'd8,  1'b1, 3'd0, 32'h10,  1'b0, 5'd0,  32'h0,   5'd2,  32'h85,  8'h84}, // R8
    '{4'd7,  1'b0, 3'd0, 32'h0,   1'b1, 5'd1,  32'h4,   5'd0,  32'hF0,  8'h80}, // R7
    '{4'd7,  1'b0, 3'd0, 32'h0,   1'b1, 5'd1,  32'h0,   5'd0,  32'hF0,  8'h80}, // R7
    '{4'd11, 1'b0, 3'd0, 32'h0,   1'b1, 5'd2,  32'hFF,  5'd2,  32'h85,  8'h80}, // R11
    '{4'd11, 1'b0, 3'd0, 32'h0,   1'b1, 5'd3,  32'h0,   5'd3,  32'h80,  8'h80}, // R11
    '{4'd11, 1'b0, 3'd0, 32'h0,   1'b0, 5'd0,  32'h0,   5'd5,  32'h0,   8'h80}, // R11
    '{4'd3,  1'b0, 3'd0, 32'h0,   1'b1, 5'd15, 32'hABC, 5'd2,  32'h5,   8'h00}, // R3
    '{4'd3,  1'b0, 3'd0, 32'h0,   1'b1, 5'd8,  32'h10,  5'd2,  32'h4,   8'h00}, // R3
    '{4'd10, 1'b1, 3'd5, 32'h55,  1'b1, 5'd10, 32'h140, 5'd2,  32'h20,  8'h20}  // R10
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus, then settle on raddr for sampling
  task automatic step(input logic dwe, input logic [2:0] dch, input logic [31:0] dptr,
                      input logic we, input logic [4:0] addr, input logic [31:0] wdata,
                      input logic [4:0] raddr);
    @(negedge clk);
    dma_we = dwe; dma_ch = dch; dma_ptr = dptr;
    reg_we = we; reg_addr = addr; reg_wdata = wdata;
    @(negedge clk);
    dma_we = 1'b0; reg_we = 1'b0; reg_addr = raddr;
    #1;
  endtask

  task automatic rd(input logic [4:0] a);
    reg_addr = a;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    rd(5'd3);
    chk("R1 masked", reg_rdata, 32'h0);
    chk("R1 irq_any", {31'b0, irq_any}, 32'h0);

    for (int i = 0; i < N_VEC; i++) begin
      vec_t v;
      v = VECS[i];
      step(v.dwe, v.dch, v.dptr, v.we, v.addr, v.wdata, v.raddr);
      chk($sformatf("R%0d vec %0d rdata", v.req, i), reg_rdata, v.exp_rd);
      chk($sformatf("R%0d vec %0d irq", v.req, i), {24'b0, irq}, {24'b0, v.exp_irq});
      chk($sformatf("R9 vec %0d any", i), {31'b0, irq_any}, {31'b0, |v.exp_irq});
    end

    // R10: DMA write and matching ack on the same channel, same cycle
    step(1'b1, 3'd2, 32'h200, 1'b1, 5'd10, 32'h140, 5'd2);
    chk("R10 raw", reg_rdata, 32'h24);
    rd(5'd10);
    chk("R10 ptr", reg_rdata, 32'h200);
    // R9: raw nonzero but nothing enabled pending
    step(1'b0, 3'd0, 32'h0, 1'b1, 5'd13, 32'h55, 5'd2);
    chk("R3 ch5 ack", reg_rdata, 32'h4);
    chk("R9 any low", {31'b0, irq_any}, 32'h0);
    step(1'b0, 3'd0, 32'h0, 1'b1, 5'd0, 32'h4, 5'd3);
    chk("R6 masked", reg_rdata, 32'h4);
    chk("R9 any high", {31'b0, irq_any}, 32'h1);
    step(1'b0, 3'd0, 32'h0, 1'b1, 5'd10, 32'h200, 5'd3);
    chk("R3 ch2 ack", reg_rdata, 32'h0);
    chk("R9 any low again", {31'b0, irq_any}, 32'h0);

    // R1: mid-run reset with state loaded
    step(1'b1, 3'd4, 32'hDEAD, 1'b1, 5'd0, 32'hFF, 5'd2);
    chk("R2 ch4 raw", reg_rdata, 32'h10);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd(5'd2);  chk("R1 raw", reg_rdata, 32'h0);
    rd(5'd0);  chk("R1 en", reg_rdata, 32'h0);
    rd(5'd12); chk("R1 ptr4", reg_rdata, 32'h0);
    chk("R1 irq", {24'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule